// File: doc/BRIEF.md
# Per-Port Network Statistics Counter Bank

This block keeps six saturating event counters for one MAC port, for use by network management software. The receive side counts CRC errors, runt frames, oversize frames and alignment errors. The transmit side counts collisions on transmit and collisions in total. The MAC logic drives one single-cycle strobe per event type. Each strobe that arrives in a cycle adds one to its counter. A counter stops at its full-scale value and does not wrap.

A host reads the counters through a byte-wide read port. The oversize counter is 8 bits wide and is read in one access. The other five counters are 16 bits wide and take two reads of the same address. The first read returns the low byte and captures the high byte into a shadow register, so the pair forms one snapshot. The second read returns the captured byte. Once its last byte has been read, a counter restarts from zero.

Top module: `stats_counters`

## Requirements
- R1: After reset every counter is zero and `rd_data_o` is zero.
- R2: The six counters sit at addresses 0 (CRC error), 1 (runt), 2 (oversize), 3 (alignment), 4 (transmit collision) and 5 (total collision). Each cycle with its strobe high adds exactly one to that counter and to no other.
- R3: A CRC error strobe counts only in a cycle where `frame_err_i` is low.
- R4: A 16-bit counter that holds FFFF hex stays at FFFF hex for further events until it is cleared.
- R5: The oversize counter is 8 bits wide and saturates at FF hex. A single read returns its value and clears it.
- R6: For a 16-bit counter, the first read returns the low byte on `rd_data_o` in the cycle after the read. The next read of the same address returns the high byte as it was at the first read, even if the counter has changed since then.
- R7: A read of any other address between the two reads cancels the pending pair. The next read of the counter returns its current low byte again.
- R8: A counter clears to zero in the cycle its last byte is read. If an event for that counter arrives in the same cycle, the counter holds 1 instead.
- R9: Reads of addresses 6 and 7 return zero and leave every counter unchanged.
- R10: `rd_data_o` keeps its value in cycles where `rd_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crc_err_i | input | 1 | Strobe: received frame with a CRC error |
| frame_err_i | input | 1 | Qualifier: the frame also has a framing error |
| runt_i | input | 1 | Strobe: runt frame received |
| oversize_i | input | 1 | Strobe: oversize frame received |
| align_err_i | input | 1 | Strobe: alignment error received |
| tx_coll_i | input | 1 | Strobe: collision on a transmitted frame |
| total_coll_i | input | 1 | Strobe: any collision |
| rd_en_i | input | 1 | Host read request, one byte per cycle |
| rd_addr_i | input | 3 | Counter address |
| rd_data_o | output | 8 | Read data, valid the cycle after the request |

## Verification
The assertions check on every cycle that no counter wraps past full scale, steps by more than one, or holds more than 1 after a clear. They also check that a CRC strobe qualified by a framing error leaves its counter unchanged, that the read data holds while no read is requested, and that unmapped addresses read as zero. Only the bench scenarios can show the meaning of the values returned. These include the byte order of a read pair and the snapshot taken at the first read, a pair cancelled by a read of another address, and the count of 1 left when an event coincides with the final read. They also include the mapping of each strobe to its own address and saturation reached through real traffic.

// File: rtl/stats_pkg.sv
package stats_pkg;
    // byte-wide host port; wide counters are exactly two bytes
    localparam int BYTE_W   = 8;
    localparam int CNT_W    = 2 * BYTE_W;
    localparam int NUM_CNT  = 6;
    localparam int ADDR_W   = 3;
    // index of the one narrow (single-byte) counter
    localparam int OVSZ_IDX = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CRC    = 3'd0,
        ADR_RUNT   = 3'd1,
        ADR_OVSZ   = 3'd2,
        ADR_ALIGN  = 3'd3,
        ADR_TXCOL  = 3'd4,
        ADR_TOTCOL = 3'd5
    } cnt_addr_e;

    function automatic int cnt_width(int idx);
        return (idx == OVSZ_IDX) ? BYTE_W : CNT_W;
    endfunction

    function automatic logic [NUM_CNT-1:0] wide_map();
        logic [NUM_CNT-1:0] m;
        for (int i = 0; i < NUM_CNT; i++) begin
            m[i] = (cnt_width(i) > BYTE_W);
        end
        return m;
    endfunction
endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = inc_i ? W'(1) : '0;
        end else if (inc_i && (cnt_q != '1)) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/stats_rd_seq.sv
module stats_rd_seq
    import stats_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd_en_i,
    input  logic [ADDR_W-1:0]              rd_addr_i,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_all_i,
    output logic [NUM_CNT-1:0]             clr_o,
    output logic [BYTE_W-1:0]              rd_data_o
);
    localparam logic [NUM_CNT-1:0] WIDE = wide_map();

    typedef struct packed {
        logic                     pend;
        logic [ADDR_W-1:0]        pend_addr;
        logic [CNT_W-BYTE_W-1:0]  shadow;
        logic [BYTE_W-1:0]        data;
    } rd_state_t;

    rd_state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        clr_o = '0;
        if (rd_en_i) begin
            if (int'(rd_addr_i) >= NUM_CNT) begin
                st_d.data = '0;
                st_d.pend = 1'b0;
            end else if (!WIDE[rd_addr_i]) begin
                st_d.data          = cnt_all_i[rd_addr_i][BYTE_W-1:0];
                clr_o[rd_addr_i]   = 1'b1;
                st_d.pend          = 1'b0;
            end else if (st_q.pend && (st_q.pend_addr == rd_addr_i)) begin
                st_d.data          = st_q.shadow;
                clr_o[rd_addr_i]   = 1'b1;
                st_d.pend          = 1'b0;
            end else begin
                st_d.data      = cnt_all_i[rd_addr_i][BYTE_W-1:0];
                st_d.shadow    = cnt_all_i[rd_addr_i][CNT_W-1:BYTE_W];
                st_d.pend      = 1'b1;
                st_d.pend_addr = rd_addr_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data_o = st_q.data;
endmodule

// File: rtl/stats_counters.sv
module stats_counters
    import stats_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              crc_err_i,
    input  logic              frame_err_i,
    input  logic              runt_i,
    input  logic              oversize_i,
    input  logic              align_err_i,
    input  logic              tx_coll_i,
    input  logic              total_coll_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [BYTE_W-1:0] rd_data_o
);
    logic [NUM_CNT-1:0]            inc_vec;
    logic [NUM_CNT-1:0]            clr_vec;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all;

    // order follows the address map in cnt_addr_e
    assign inc_vec[ADR_CRC]    = crc_err_i & ~frame_err_i;
    assign inc_vec[ADR_RUNT]   = runt_i;
    assign inc_vec[ADR_OVSZ]   = oversize_i;
    assign inc_vec[ADR_ALIGN]  = align_err_i;
    assign inc_vec[ADR_TXCOL]  = tx_coll_i;
    assign inc_vec[ADR_TOTCOL] = total_coll_i;

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        localparam int W = cnt_width(i);
        logic [W-1:0] cnt;
        sat_counter #(.W(W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc_i (inc_vec[i]),
            .clr_i (clr_vec[i]),
            .cnt_o (cnt)
        );
        assign cnt_all[i] = CNT_W'(cnt);
    end

    stats_rd_seq u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (rd_en_i),
        .rd_addr_i (rd_addr_i),
        .cnt_all_i (cnt_all),
        .clr_o     (clr_vec),
        .rd_data_o (rd_data_o)
    );
endmodule

// File: rtl/stats_counters_chk.sv
module stats_counters_chk
    import stats_pkg::*;
(
    input logic                          clk,
    input logic                          rst_n,
    input logic                          crc_err_i,
    input logic                          frame_err_i,
    input logic                          rd_en_i,
    input logic [ADDR_W-1:0]             rd_addr_i,
    input logic [BYTE_W-1:0]             rd_data_o,
    input logic [NUM_CNT-1:0]            clr_vec,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all
);
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
        localparam logic [CNT_W-1:0] MAXV = CNT_W'((1 << cnt_width(i)) - 1);

        // R4 R5
        no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_all[i] == MAXV && !clr_vec[i]) |=> cnt_all[i] == MAXV);

        // R2
        single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !clr_vec[i] |=> (cnt_all[i] == $past(cnt_all[i]) ||
                             cnt_all[i] == $past(cnt_all[i]) + CNT_W'(1)));

        // R8
        clear_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clr_vec[i] |=> cnt_all[i] <= CNT_W'(1));
    end

    // R3
    crc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_err_i && frame_err_i && !clr_vec[0]) |=> $stable(cnt_all[0]));

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rd_data_o));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && int'(rd_addr_i) >= NUM_CNT) |=> rd_data_o == '0);

    // R9
    unmapped_noclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && int'(rd_addr_i) >= NUM_CNT) |-> clr_vec == '0);
endmodule

bind stats_counters stats_counters_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .crc_err_i   (crc_err_i),
    .frame_err_i (frame_err_i),
    .rd_en_i     (rd_en_i),
    .rd_addr_i   (rd_addr_i),
    .rd_data_o   (rd_data_o),
    .clr_vec     (clr_vec),
    .cnt_all     (cnt_all)
);

// File: tb/stats_counters_bench.sv
module stats_counters_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] ev;
    logic       frame_err;
    logic       rd_en;
    logic [2:0] rd_addr;
    logic [7:0] rd_data;
    int         vectors = 0;
    int         miscompares = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    stats_counters u_stats_counters (
        .clk          (clk),
        .rst_n        (rst_n),
        .crc_err_i    (ev[0]),
        .frame_err_i  (frame_err),
        .runt_i       (ev[1]),
        .oversize_i   (ev[2]),
        .align_err_i  (ev[3]),
        .tx_coll_i    (ev[4]),
        .total_coll_i (ev[5]),
        .rd_en_i      (rd_en),
        .rd_addr_i    (rd_addr),
        .rd_data_o    (rd_data)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic strobe(int idx, int n);
        ev[idx] = 1'b1;
        repeat (n) @(negedge clk);
        ev[idx] = 1'b0;
    endtask

    task automatic read_byte(logic [2:0] a, output logic [7:0] d);
        rd_en   = 1'b1;
        rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d     = rd_data;
    endtask

    task automatic read_cnt(logic [2:0] a, output logic [15:0] v);
        logic [7:0] lo, hi;
        read_byte(a, lo);
        if (a == 3'd2) begin
            v = {8'h00, lo};
        end else begin
            read_byte(a, hi);
            v = {hi, lo};
        end
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1 rd_data", {8'h00, rd_data}, 16'h0000);
        for (int i = 0; i < 6; i++) begin
            read_cnt(3'(i), v);
            check("R1 counter", v, 16'h0000);
        end
    endtask

    task automatic t_increment();
        logic [15:0] v;
        for (int i = 0; i < 6; i++) strobe(i, i + 2);
        for (int i = 0; i < 6; i++) begin
            read_cnt(3'(i), v);
            check("R2 per-address count", v, 16'(i + 2));
        end
    endtask

    task automatic t_crc_gate();
        logic [15:0] v;
        frame_err = 1'b1;
        strobe(0, 4);
        frame_err = 1'b0;
        strobe(0, 3);
        read_cnt(3'd0, v);
        check("R3 crc with framing error", v, 16'd3);
    endtask

    task automatic t_snapshot();
        logic [7:0]  d;
        logic [15:0] v;
        strobe(0, 255);
        read_byte(3'd0, d);
        check("R6 low byte", {8'h00, d}, 16'h00FF);
        strobe(0, 1);
        read_byte(3'd0, d);
        check("R6 high byte snapshot", {8'h00, d}, 16'h0000);
        read_cnt(3'd0, v);
        check("R8 cleared after final byte", v, 16'h0000);
    endtask

    task automatic t_restart();
        logic [7:0]  d;
        logic [15:0] v;
        strobe(1, 5);
        read_byte(3'd1, d);
        check("R7 first low byte", {8'h00, d}, 16'h0005);
        read_byte(3'd3, d);
        read_byte(3'd1, d);
        check("R7 low byte after other address", {8'h00, d}, 16'h0005);
        read_byte(3'd1, d);
        check("R7 high byte", {8'h00, d}, 16'h0000);
        read_cnt(3'd1, v);
        check("R7 runt cleared", v, 16'h0000);
        read_cnt(3'd3, v);
        check("R7 align untouched", v, 16'h0000);
    endtask

    task automatic t_clear_collide();
        logic [7:0]  d;
        logic [15:0] v;
        strobe(4, 3);
        read_byte(3'd4, d);
        check("R8 low byte", {8'h00, d}, 16'h0003);
        ev[4] = 1'b1;
        read_byte(3'd4, d);
        ev[4] = 1'b0;
        check("R8 high byte", {8'h00, d}, 16'h0000);
        read_cnt(3'd4, v);
        check("R8 event on clear leaves 1", v, 16'h0001);
    endtask

    task automatic t_unmapped();
        logic [7:0]  d;
        logic [15:0] v;
        strobe(5, 2);
        read_byte(3'd6, d);
        check("R9 address 6", {8'h00, d}, 16'h0000);
        read_byte(3'd7, d);
        check("R9 address 7", {8'h00, d}, 16'h0000);
        read_cnt(3'd5, v);
        check("R9 counter unchanged", v, 16'h0002);
    endtask

    task automatic t_hold();
        logic [7:0] d;
        strobe(3, 9);
        read_byte(3'd3, d);
        repeat (3) @(negedge clk);
        check("R10 data held while idle", {8'h00, rd_data}, 16'h0009);
        read_byte(3'd3, d);
        check("R10 high byte", {8'h00, d}, 16'h0000);
    endtask

    task automatic t_oversize_sat();
        logic [15:0] v;
        strobe(2, 300);
        read_cnt(3'd2, v);
        check("R5 oversize saturates", v, 16'h00FF);
        read_cnt(3'd2, v);
        check("R5 single read clears", v, 16'h0000);
    endtask

    task automatic t_sat16();
        logic [15:0] v;
        strobe(0, 65540);
        read_cnt(3'd0, v);
        check("R4 16-bit saturates", v, 16'hFFFF);
        read_cnt(3'd0, v);
        check("R4 cleared after read", v, 16'h0000);
    endtask

    initial begin
        rst_n     = 1'b0;
        ev        = '0;
        frame_err = 1'b0;
        rd_en     = 1'b0;
        rd_addr   = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_increment();
        t_crc_gate();
        t_snapshot();
        t_restart();
        t_clear_collide();
        t_unmapped();
        t_hold();
        t_oversize_sat();
        t_sat16();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule